// File: doc/BRIEF.md
# Decode-Stage Register File with Write-Back Forwarding

This block holds the architectural integer registers of a five-stage pipelined processor. The decode stage reads two operands through two independent, purely combinational read ports. The write-back stage writes one result per cycle through a single write port. All storage updates happen on the rising clock edge, and no logic runs on the opposite edge.

A value written in cycle N is not held in the array until the edge that ends cycle N. A decode-stage read of the same register in cycle N would therefore return the stale value. To prevent this, each read port compares its own address with the write address. When the two match and the write is live, the port returns the incoming write data instead of the array contents.

Register zero is hard-wired to zero. It is never stored, never overwritten and never forwarded. All ports are plain level signals with no handshake. A read result is valid in the same cycle as its address, and the block accepts a write in every cycle.

Top module: `bypass_regfile`

## Requirements
- R1: An active-low asynchronous reset (`rst_n` = 0) clears every register. After reset is released, a read of any register returns zero until that register is written.
- R2: When `wr_en` = 1 and `wr_addr` is nonzero at a rising edge, `wr_data` is stored in register `wr_addr`. From the following cycle on, reads of that address return the stored value.
- R3: When `wr_en` = 0, no register changes, whatever the values on `wr_addr` and `wr_data`.
- R4: A read of address 0 on either port always returns zero. A write to address 0 stores nothing.
- R5: When `wr_en` = 1, `wr_addr` is nonzero and a read address equals `wr_addr`, that read port returns `wr_data` in the same cycle, combinationally.
- R6: A live write to address 0 is never forwarded. A port reading address 0 in that cycle still returns zero.
- R7: When both read addresses equal a live, nonzero write address, both ports return `wr_data` in that cycle.
- R8: A read port whose address differs from the write address returns the stored contents of its own register, unaffected by the write in progress.
- R9: With `wr_en` = 0, a read address equal to `wr_addr` returns the stored value, not `wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all storage updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset that clears all registers |
| rd_addr_a | input | 5 | Register index for read port A |
| rd_addr_b | input | 5 | Register index for read port B |
| wr_en | input | 1 | Write strobe from write-back |
| wr_addr | input | 5 | Register index to write |
| wr_data | input | 32 | Value to write |
| rd_data_a | output | 32 | Operand returned by read port A |
| rd_data_b | output | 32 | Operand returned by read port B |

## Verification
The bench reads every register right after reset to confirm the cleared state. It then writes distinct values and reads them back in the following cycles, which separates a correct commit from a missing or misdirected one.

Same-cycle patterns are the core of the test. In these, one port, both ports or neither port aims at the live write address. These patterns separate forwarding from stale array reads, and they show whether the two ports use their own comparators.

Writes with the strobe low, and writes to register zero, are placed under matching read addresses. These show that neither case forwards or stores anything. A mid-run reset checks that previously written contents are cleared.

// File: rtl/bypass_rf_pkg.sv
package bypass_rf_pkg;
  localparam int RF_DEPTH_DEF = 32;
  localparam int RF_WIDTH_DEF = 32;
  localparam int RF_RD_PORTS  = 2;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_ARRAY = 2'd1,
    SRC_FWD   = 2'd2
  } rd_src_e;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic [AW-1:0]               waddr_i,
  input  logic [WIDTH-1:0]            wdata_i,
  output logic [DEPTH-1:0][WIDTH-1:0] rows_o
);
  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    if (r == 0) begin : g_zero
      assign rows_o[r] = '0;
    end else begin : g_live
      logic             hit;
      logic [WIDTH-1:0] q;
      assign hit = we_i && (waddr_i == AW'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wdata_i;
      end
      assign rows_o[r] = q;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> (rows_o == '0));

  // R3
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(we_i)) |-> (rows_o == $past(rows_o)));

  // R4
  row0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rows_o[0] == '0);
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import bypass_rf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [AW-1:0]               raddr_i,
  input  logic [DEPTH-1:0][WIDTH-1:0] rows_i,
  input  logic                        we_i,
  input  logic [AW-1:0]               waddr_i,
  input  logic [WIDTH-1:0]            wdata_i,
  output logic [WIDTH-1:0]            rdata_o
);
  rd_src_e    src;
  logic       addr_match;
  logic       wr_live;

  assign addr_match = (raddr_i == waddr_i);
  assign wr_live    = we_i && (waddr_i != '0);

  always_comb begin
    if (raddr_i == '0)             src = SRC_ZERO;
    else if (wr_live && addr_match) src = SRC_FWD;
    else                            src = SRC_ARRAY;
  end

  always_comb begin
    unique case (src)
      SRC_ZERO: rdata_o = '0;
      SRC_FWD:  rdata_o = wdata_i;
      default:  rdata_o = rows_i[raddr_i];
    endcase
  end

  // R4
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr_i == '0) |-> (rdata_o == '0));

  // R5
  fwd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && waddr_i != '0 && raddr_i == waddr_i) |-> (rdata_o == wdata_i));
endmodule

// File: rtl/bypass_regfile.sv
module bypass_regfile
  import bypass_rf_pkg::*;
#(
  parameter int DEPTH = RF_DEPTH_DEF,
  parameter int WIDTH = RF_WIDTH_DEF,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr_a,
  input  logic [AW-1:0]    rd_addr_b,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data_a,
  output logic [WIDTH-1:0] rd_data_b
);
  logic [DEPTH-1:0][WIDTH-1:0] rows;
  logic [AW-1:0]               raddr_v [RF_RD_PORTS];
  logic [WIDTH-1:0]            rdata_v [RF_RD_PORTS];

  assign raddr_v[0] = rd_addr_a;
  assign raddr_v[1] = rd_addr_b;
  assign rd_data_a  = rdata_v[0];
  assign rd_data_b  = rdata_v[1];

  rf_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .rows_o  (rows)
  );

  for (genvar p = 0; p < RF_RD_PORTS; p++) begin : g_port
    rf_read_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .raddr_i (raddr_v[p]),
      .rows_i  (rows),
      .we_i    (wr_en),
      .waddr_i (wr_addr),
      .wdata_i (wr_data),
      .rdata_o (rdata_v[p])
    );

    // R2
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en) && $past(wr_addr) != '0 &&
       raddr_v[p] == $past(wr_addr) && !(wr_en && wr_addr == raddr_v[p]))
      |-> (rdata_v[p] == $past(wr_data)));
  end

  // R7
  dual_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && rd_addr_a == wr_addr && rd_addr_b == wr_addr)
    |-> (rd_data_a == wr_data && rd_data_b == wr_data));
endmodule

// File: tb/bypass_regfile_test.sv
module bypass_regfile_test;
  localparam int AW = 5;
  localparam int W  = 32;
  localparam int N  = 32;

  typedef struct {
    string      tag;
    int         port;
    logic [W-1:0] exp;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ra = '0, rb = '0, wa = '0;
  logic          we = 1'b0;
  logic [W-1:0]  wd = '0;
  logic [W-1:0]  da, db;

  item_t        sb_q [$];
  logic [W-1:0] model [N];
  int           n_cmp = 0, n_bad = 0;
  bit           done = 0;
  event         sample_ev;

  always #4 clk = ~clk;

  bypass_regfile uut (
    .clk(clk), .rst_n(rst_n), .rd_addr_a(ra), .rd_addr_b(rb),
    .wr_en(we), .wr_addr(wa), .wr_data(wd), .rd_data_a(da), .rd_data_b(db)
  );

  function automatic logic [W-1:0] expect_rd(logic [AW-1:0] addr);
    if (addr == '0) return '0;
    if (we && wa != '0 && wa == addr) return wd;
    return model[addr];
  endfunction

  task automatic step(string tag, logic [AW-1:0] a, logic [AW-1:0] b,
                      logic e, logic [AW-1:0] w, logic [W-1:0] d);
    @(negedge clk);
    ra = a; rb = b; we = e; wa = w; wd = d;
    sb_q.push_back('{tag, 0, expect_rd(a)});
    sb_q.push_back('{tag, 1, expect_rd(b)});
    -> sample_ev;
    if (e && w != '0) model[w] = d;
  endtask

  initial begin : monitor
    forever begin
      @(sample_ev);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [W-1:0] act;
        it  = sb_q.pop_front();
        act = (it.port == 0) ? da : db;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s port %0d: actual %h expected %h", it.tag, it.port, act, it.exp);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    we = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) model[i] = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : driver
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: every register reads zero after reset
    for (int i = 0; i < N; i += 2) step("R1", AW'(i), AW'(i + 1), 1'b0, '0, '0);
    // R2: write distinct values, read back next cycle
    for (int i = 1; i < N; i++) step("R2", '0, '0, 1'b1, AW'(i), 32'hA500_0000 + W'(i) * 32'h0101);
    for (int i = 1; i < N; i += 2) step("R2", AW'(i), AW'((i + 1) % N), 1'b0, '0, '0);
    // R3: strobe low with garbage address/data leaves contents unchanged
    step("R3", 5'd0, 5'd0, 1'b0, 5'd7, 32'hDEAD_BEEF);
    step("R3", 5'd7, 5'd8, 1'b0, 5'd8, 32'hCAFE_F00D);
    // R9: strobe low, matching address returns stored value
    step("R9", 5'd12, 5'd12, 1'b0, 5'd12, 32'h1234_5678);
    // R4: write to register 0 stores nothing
    step("R4", 5'd0, 5'd3, 1'b1, 5'd0, 32'hFFFF_FFFF);
    step("R4", 5'd0, 5'd0, 1'b0, '0, '0);
    // R6: live write to 0 under matching read addresses is not forwarded
    step("R6", 5'd0, 5'd0, 1'b1, 5'd0, 32'h5A5A_5A5A);
    // R5: port A forwards, port B reads elsewhere (R8)
    step("R5", 5'd9, 5'd10, 1'b1, 5'd9, 32'h0BAD_C0DE);
    step("R8", 5'd10, 5'd9, 1'b1, 5'd9, 32'h7777_0001);
    step("R5", 5'd4, 5'd31, 1'b1, 5'd31, 32'hFEED_0031);
    // R7: both ports forward the same write
    step("R7", 5'd20, 5'd20, 1'b1, 5'd20, 32'h2020_2020);
    step("R7", 5'd20, 5'd20, 1'b1, 5'd20, 32'h3030_3030);
    step("R2", 5'd20, 5'd9, 1'b0, '0, '0);
    // back-to-back writes to the same register with reads in between
    for (int k = 0; k < 8; k++) step("R5", 5'd15, AW'(k), 1'b1, 5'd15, W'(k) * 32'h1111_1111);
    step("R2", 5'd15, 5'd15, 1'b0, '0, '0);
    // R1: mid-run reset clears written contents
    do_reset();
    for (int i = 0; i < N; i += 2) step("R1", AW'(i), AW'(i + 1), 1'b0, '0, '0);
    @(negedge clk);
    #2;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    #(8 * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule